// File: doc/BRIEF.md
# DMA Address Translation Unit

This block turns 32-bit device DMA addresses into physical addresses by looking up one entry in a single-level translation table kept in memory. Software programs a 64-bit control register and a 64-bit table base register. Each register can be reached as a whole 64-bit word or as two 32-bit halves. The control register holds the enable bit, the table-walk granule and the table size. When translation is off, addresses pass straight through.

One translation is handled at a time. A request is accepted while the block is idle. If a table entry is needed, the block issues one 64-bit memory read at base plus an index derived from the address, and waits for the memory acknowledge. It then returns the physical address, the page offset mask and a permission code. The fetched entry arrives with its bytes in big-endian order. The entry decides whether the page is 8K or 64K and whether it may be written.

The controller has three states: `ST_IDLE`, `ST_FETCH` and `ST_RESP`. The transitions are:
- IDLE to FETCH on an accepted request that needs a table entry.
- IDLE to RESP on an accepted request in passthrough or with an unsupported size.
- FETCH to RESP on the memory acknowledge.
- RESP to IDLE always.

Top module: `dma_xlate_unit`

## Requirements
- R1: After reset, `req_ready` is 1, `mem_req` and `rsp_valid` are 0, and both registers read as zero.
- R2: Register offsets are 0x00 (control) and 0x08 (base). A wide access at an offset covers the whole register. A narrow access at the offset covers bits 63:32, and a narrow access at offset+4 covers bits 31:0. Narrow writes take `cfg_wdata[31:0]` and leave the other half unchanged. Narrow reads return the half in `cfg_rdata[31:0]` with the upper bits zero.
- R3: Writes to the flush offsets 0x10 and 0x14 change nothing, and reads there return zero.
- R4: With control bit 0 clear, the response follows in the cycle after acceptance, with no memory read. The physical address is the input address zero-extended, the mask is 0x1FFF and the permission is read-write. Permission codes are: 00 none, 01 read-only, 10 read-write.
- R5: With control bit 2 clear (8K walk) and size s = control bits 18:16, the entry is read at base + ((addr & (2^(23+s)−1) & ~0x1FFF) >> 10).
- R6: With control bit 2 set (64K walk) and s of 0 to 5, the entry is read at base + ((addr & (2^(26+s)−1) & ~0xFFFF) >> 13).
- R7: A 64K walk with s of 6 or 7 makes no memory read. It responds in the cycle after acceptance with permission none, address 0 and mask 0.
- R8: Byte lane k of `mem_rdata` (bits 8k+7:8k) holds the byte at `mem_addr`+k. The entry is formed with lane 0 as its most significant byte.
- R9: An entry with bit 63 clear gives permission none, address 0 and mask 0.
- R10: For a valid entry, bit 1 set gives read-write and bit 1 clear gives read-only.
- R11: For a valid entry with bit 61 set, the page is 64K: the address is {entry[40:16], addr[15:0]} and the mask is 0xFFFF. With bit 61 clear, the address is {entry[40:13], addr[12:0]} and the mask is 0x1FFF.
- R12: Only one translation is in flight. `req_ready` is low from acceptance until the response cycle ends. `mem_req` holds with a stable `mem_addr` until `mem_ack`. `rsp_valid` is a one-cycle pulse in the cycle after the acknowledge.
- R13: A register write in the same cycle as request acceptance does not affect that translation; it uses the values held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Register access strobe |
| cfg_write | input | 1 | 1 write, 0 read |
| cfg_wide | input | 1 | 1 for a 64-bit access, 0 for 32-bit |
| cfg_addr | input | 5 | Register byte offset |
| cfg_wdata | input | 64 | Write data |
| cfg_rdata | output | 64 | Read data, valid combinationally during a read |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Device address to translate |
| req_ready | output | 1 | Block idle, request accepted on this edge |
| mem_req | output | 1 | Table entry read pending |
| mem_addr | output | 64 | Table entry byte address |
| mem_ack | input | 1 | Read data present on `mem_rdata` |
| mem_rdata | input | 64 | Entry bytes, lane k = byte at address+k |
| rsp_valid | output | 1 | Result pulse |
| rsp_paddr | output | 41 | Translated physical address |
| rsp_mask | output | 32 | Page offset mask |
| rsp_perm | output | 2 | Permission code |

## Verification
A register write and a request acceptance can fall on the same clock edge. The bench provokes this by holding a narrow write that clears the control lower half while presenting a request. It judges the result by checking that the table read and the returned address follow the configuration held before the write, and that the next request passes through. The memory acknowledge is also given with random delays, including in the first fetch cycle, so the acknowledge and the fetch-state entry meet in every order.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
    localparam int VA_W          = 32;
    localparam int PA_W          = 41;
    localparam int REG_W         = 64;
    localparam int HALF_W        = REG_W / 2;
    localparam int CFG_AW        = 5;
    localparam int SZ_W          = 3;
    localparam int N_SIZES       = 1 << SZ_W;
    localparam int SMALL_LOG     = 13;
    localparam int LARGE_LOG     = 16;
    localparam int ENTRY_LOG     = 3;
    localparam int TBL8_MIN_LOG  = 23;
    localparam int TBL64_MIN_LOG = 26;
    localparam int TBL64_LAST    = 5;
    localparam int CTL_EN_BIT    = 0;
    localparam int CTL_GRAN_BIT  = 2;
    localparam int CTL_SZ_LSB    = 16;
    localparam int ENT_VALID_BIT = 63;
    localparam int ENT_BIG_BIT   = 61;
    localparam int ENT_WR_BIT    = 1;
    localparam int ENT_PHYS_MSB  = PA_W - 1;
    localparam int N_REGS        = 2;

    typedef enum logic [1:0] {
        PERM_NONE = 2'b00,
        PERM_RO   = 2'b01,
        PERM_RW   = 2'b10
    } perm_e;

    typedef struct packed {
        logic [PA_W-1:0] paddr;
        logic [VA_W-1:0] mask;
        perm_e           perm;
    } xres_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_RESP
    } xstate_e;
endpackage

// File: rtl/xlate_regs.sv
module xlate_regs
    import xlate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_wide,
    input  logic [CFG_AW-1:0] acc_addr,
    input  logic [REG_W-1:0]  acc_wdata,
    output logic [REG_W-1:0]  acc_rdata,
    output logic [REG_W-1:0]  ctrl_q,
    output logic [REG_W-1:0]  base_q
);
    logic [N_REGS-1:0][REG_W-1:0] regs_q;
    logic [1:0]                   slot;
    logic                         low_half;
    logic                         aligned;
    logic                         hit;
    logic [REG_W-1:0]             sel;

    assign slot     = acc_addr[4:3];
    assign low_half = acc_addr[2];
    assign aligned  = (acc_addr[1:0] == 2'b00);
    assign hit      = acc_valid && aligned && (slot < 2'(N_REGS));

    function automatic logic [REG_W-1:0] merge(input logic [REG_W-1:0] old,
                                               input logic wide, input logic low,
                                               input logic [REG_W-1:0] wd);
        logic [REG_W-1:0] r;
        r = old;
        if (low)       r[HALF_W-1:0]     = wd[HALF_W-1:0];
        else if (wide) r                 = wd;
        else           r[REG_W-1:HALF_W] = wd[HALF_W-1:0];
        return r;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else if (hit && acc_write) begin
            for (int r = 0; r < N_REGS; r++) begin
                if (slot == 2'(r)) regs_q[r] <= merge(regs_q[r], acc_wide, low_half, acc_wdata);
            end
        end
    end

    always_comb begin
        sel       = regs_q[slot[0]];
        acc_rdata = '0;
        if (hit && !acc_write) begin
            if (low_half)      acc_rdata = {{HALF_W{1'b0}}, sel[HALF_W-1:0]};
            else if (acc_wide) acc_rdata = sel;
            else               acc_rdata = {{HALF_W{1'b0}}, sel[REG_W-1:HALF_W]};
        end
    end

    assign ctrl_q = regs_q[0];
    assign base_q = regs_q[1];
endmodule

// File: rtl/xlate_index.sv
module xlate_index
    import xlate_pkg::*;
(
    input  logic [REG_W-1:0] ctrl,
    input  logic [REG_W-1:0] base,
    input  logic [VA_W-1:0]  vaddr,
    output logic             walk_en,
    output logic             no_table,
    output logic [REG_W-1:0] tbl_addr
);
    logic [N_SIZES-1:0][REG_W-1:0] off_small;
    logic [N_SIZES-1:0][REG_W-1:0] off_large;
    logic [REG_W-1:0]              va_ext;
    logic [SZ_W-1:0]               sz;
    logic                          big_walk;

    assign va_ext = REG_W'(vaddr);

    generate
        for (genvar g = 0; g < N_SIZES; g++) begin : g_size
            localparam int SPAN8 = TBL8_MIN_LOG + g;
            localparam logic [REG_W-1:0] MASK8 =
                ((REG_W'(1) << SPAN8) - REG_W'(1)) & ~((REG_W'(1) << SMALL_LOG) - REG_W'(1));
            assign off_small[g] = (va_ext & MASK8) >> (SMALL_LOG - ENTRY_LOG);
            if (g <= TBL64_LAST) begin : g_large
                localparam int SPAN64 = TBL64_MIN_LOG + g;
                localparam logic [REG_W-1:0] MASK64 =
                    ((REG_W'(1) << SPAN64) - REG_W'(1)) & ~((REG_W'(1) << LARGE_LOG) - REG_W'(1));
                assign off_large[g] = (va_ext & MASK64) >> (LARGE_LOG - ENTRY_LOG);
            end else begin : g_none
                assign off_large[g] = '0;
            end
        end
    endgenerate

    assign sz       = ctrl[CTL_SZ_LSB +: SZ_W];
    assign big_walk = ctrl[CTL_GRAN_BIT];
    assign walk_en  = ctrl[CTL_EN_BIT];
    assign no_table = big_walk && (sz > SZ_W'(TBL64_LAST));
    assign tbl_addr = base + (big_walk ? off_large[sz] : off_small[sz]);
endmodule

// File: rtl/xlate_entry.sv
module xlate_entry
    import xlate_pkg::*;
(
    input  logic [REG_W-1:0] lanes,
    input  logic [VA_W-1:0]  vaddr,
    output xres_t            res
);
    localparam int N_BYTES = REG_W / 8;

    logic [REG_W-1:0] ent;

    generate
        for (genvar b = 0; b < N_BYTES; b++) begin : g_swap
            assign ent[REG_W-1-8*b -: 8] = lanes[8*b +: 8];
        end
    endgenerate

    always_comb begin
        res = '0;
        if (ent[ENT_VALID_BIT]) begin
            res.perm = ent[ENT_WR_BIT] ? PERM_RW : PERM_RO;
            if (ent[ENT_BIG_BIT]) begin
                res.paddr = {ent[ENT_PHYS_MSB:LARGE_LOG], vaddr[LARGE_LOG-1:0]};
                res.mask  = VA_W'((64'd1 << LARGE_LOG) - 64'd1);
            end else begin
                res.paddr = {ent[ENT_PHYS_MSB:SMALL_LOG], vaddr[SMALL_LOG-1:0]};
                res.mask  = VA_W'((64'd1 << SMALL_LOG) - 64'd1);
            end
        end
    end
endmodule

// File: rtl/xlate_fsm.sv
module xlate_fsm
    import xlate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             walk_en,
    input  logic             no_table,
    input  logic [REG_W-1:0] tbl_addr,
    input  logic             mem_ack,
    input  xres_t            entry_res,
    output logic             req_ready,
    output logic             mem_req,
    output logic             rsp_valid,
    output logic [REG_W-1:0] mem_addr,
    output logic [VA_W-1:0]  va_q,
    output xres_t            res_q
);
    xstate_e state_q, state_d;

    function automatic xres_t direct_res(input logic en, input logic [VA_W-1:0] va);
        xres_t r;
        r = '0;
        if (!en) begin
            r.paddr = PA_W'(va);
            r.mask  = VA_W'((64'd1 << SMALL_LOG) - 64'd1);
            r.perm  = PERM_RW;
        end
        return r;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = (walk_en && !no_table) ? ST_FETCH : ST_RESP;
            ST_FETCH: if (mem_ack)   state_d = ST_RESP;
            ST_RESP:                 state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready = 1'b0;
        mem_req   = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_FETCH: mem_req   = 1'b1;
            ST_RESP:  rsp_valid = 1'b1;
            default:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q     <= '0;
            mem_addr <= '0;
            res_q    <= '0;
        end else if (req_ready && req_valid) begin
            va_q     <= req_vaddr;
            mem_addr <= tbl_addr;
            res_q    <= direct_res(walk_en, req_vaddr);
        end else if (mem_req && mem_ack) begin
            res_q    <= entry_res;
        end
    end
endmodule

// File: rtl/dma_xlate_unit.sv
module dma_xlate_unit
    import xlate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic              cfg_write,
    input  logic              cfg_wide,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    output logic              req_ready,
    output logic              mem_req,
    output logic [REG_W-1:0]  mem_addr,
    input  logic              mem_ack,
    input  logic [REG_W-1:0]  mem_rdata,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [VA_W-1:0]   rsp_mask,
    output logic [1:0]        rsp_perm
);
    logic [REG_W-1:0] ctrl_q, base_q, tbl_addr;
    logic             walk_en, no_table;
    logic [VA_W-1:0]  va_q;
    xres_t            entry_res, res_q;

    xlate_regs u_regs (
        .clk(clk), .rst_n(rst_n), .acc_valid(cfg_valid), .acc_write(cfg_write),
        .acc_wide(cfg_wide), .acc_addr(cfg_addr), .acc_wdata(cfg_wdata),
        .acc_rdata(cfg_rdata), .ctrl_q(ctrl_q), .base_q(base_q)
    );

    xlate_index u_index (
        .ctrl(ctrl_q), .base(base_q), .vaddr(req_vaddr),
        .walk_en(walk_en), .no_table(no_table), .tbl_addr(tbl_addr)
    );

    xlate_entry u_entry (
        .lanes(mem_rdata), .vaddr(va_q), .res(entry_res)
    );

    xlate_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .walk_en(walk_en), .no_table(no_table), .tbl_addr(tbl_addr),
        .mem_ack(mem_ack), .entry_res(entry_res), .req_ready(req_ready),
        .mem_req(mem_req), .rsp_valid(rsp_valid), .mem_addr(mem_addr),
        .va_q(va_q), .res_q(res_q)
    );

    assign rsp_paddr = res_q.paddr;
    assign rsp_mask  = res_q.mask;
    assign rsp_perm  = res_q.perm;
endmodule

// File: rtl/xlate_sva.sv
module xlate_sva
    import xlate_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             mem_req,
    input logic             mem_ack,
    input logic [REG_W-1:0] mem_addr,
    input logic             rsp_valid,
    input logic [PA_W-1:0]  rsp_paddr,
    input logic [VA_W-1:0]  rsp_mask,
    input logic [1:0]       rsp_perm
);
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> req_ready && !mem_req && !rsp_valid);

    a_r12_one_inflight: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    a_r12_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

    a_r12_rsp_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |=> rsp_valid && !mem_req);

    a_r12_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid && req_ready);

    a_r12_fetch_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready && !rsp_valid);

    a_r9_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_perm == 2'b00 |-> rsp_mask == '0 && rsp_paddr == '0);

    a_r10_perm_code: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_perm != 2'b11);

    a_r11_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_perm != 2'b00 |-> rsp_mask == 32'h0000_1FFF || rsp_mask == 32'h0000_FFFF);
endmodule

bind dma_xlate_unit xlate_sva u_sva (.*);

// File: tb/dma_xlate_unit_tb_top.sv
module dma_xlate_unit_tb_top;
    logic        clk;
    logic        rst_n;
    logic        cfg_valid, cfg_write, cfg_wide;
    logic [4:0]  cfg_addr;
    logic [63:0] cfg_wdata, cfg_rdata;
    logic        req_valid;
    logic [31:0] req_vaddr;
    logic        req_ready, mem_req, mem_ack, rsp_valid;
    logic [63:0] mem_addr, mem_rdata;
    logic [40:0] rsp_paddr;
    logic [31:0] rsp_mask;
    logic [1:0]  rsp_perm;

    int total = 0;
    int bad   = 0;
    logic [63:0] sh_ctrl = '0;
    logic [63:0] sh_base = '0;

    initial clk = 1'b0;
    always #4 clk = ~clk;

    dma_xlate_unit dut_i (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] lanes_of(input logic [63:0] e);
        logic [63:0] l;
        for (int k = 0; k < 8; k++) l[8*k +: 8] = e[63-8*k -: 8];
        return l;
    endfunction

    function automatic void sh_apply(input logic [4:0] a, input bit wide, input logic [63:0] d);
        logic [63:0] r;
        if (a[1:0] != 2'b00 || a[4:3] > 2'd1) return;
        r = (a[4:3] == 2'd0) ? sh_ctrl : sh_base;
        if (a[2])     r[31:0]  = d[31:0];
        else if (wide) r       = d;
        else          r[63:32] = d[31:0];
        if (a[4:3] == 2'd0) sh_ctrl = r; else sh_base = r;
    endfunction

    function automatic logic [63:0] exp_rd(input logic [4:0] a, input bit wide);
        logic [63:0] r;
        if (a[1:0] != 2'b00 || a[4:3] > 2'd1) return 64'd0;
        r = (a[4:3] == 2'd0) ? sh_ctrl : sh_base;
        if (a[2]) return {32'd0, r[31:0]};
        if (wide) return r;
        return {32'd0, r[63:32]};
    endfunction

    function automatic void model(input logic [63:0] ctrl, input logic [63:0] base,
                                  input logic [31:0] va, input logic [63:0] ent,
                                  output bit fetch, output logic [63:0] ea,
                                  output logic [40:0] pa, output logic [31:0] mk,
                                  output logic [1:0] pm);
        int          sz;
        logic [63:0] span;
        sz = int'(ctrl[18:16]);
        fetch = 0; ea = '0; pa = '0; mk = '0; pm = 2'b00;
        if (!ctrl[0]) begin
            pa = {9'd0, va}; mk = 32'h1FFF; pm = 2'b10;
            return;
        end
        if (ctrl[2] && sz > 5) return;
        fetch = 1;
        if (ctrl[2]) begin
            span = (64'd1 << (26 + sz)) - 64'd1;
            ea = base + (({32'd0, va} & span & ~64'hFFFF) >> 13);
        end else begin
            span = (64'd1 << (23 + sz)) - 64'd1;
            ea = base + (({32'd0, va} & span & ~64'h1FFF) >> 10);
        end
        if (!ent[63]) return;
        pm = ent[1] ? 2'b10 : 2'b01;
        if (ent[61]) begin pa = {ent[40:16], va[15:0]}; mk = 32'hFFFF; end
        else         begin pa = {ent[40:13], va[12:0]}; mk = 32'h1FFF; end
    endfunction

    task automatic cfg_wr(input logic [4:0] a, input bit wide, input logic [63:0] d);
        @(negedge clk);
        cfg_valid = 1; cfg_write = 1; cfg_wide = wide; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_valid = 0; cfg_write = 0;
        sh_apply(a, wide, d);
    endtask

    task automatic cfg_chk(input logic [4:0] a, input bit wide, input string tag);
        @(negedge clk);
        cfg_valid = 1; cfg_write = 0; cfg_wide = wide; cfg_addr = a;
        #1 chk(tag, cfg_rdata, exp_rd(a, wide));
        @(negedge clk);
        cfg_valid = 0;
    endtask

    task automatic set_cfg(input logic [63:0] c, input logic [63:0] b);
        int form;
        form = $urandom_range(0, 2);
        if (form == 0) begin
            cfg_wr(5'h00, 1, c); cfg_wr(5'h08, 1, b);
        end else if (form == 1) begin
            cfg_wr(5'h00, 0, {$urandom, c[63:32]}); cfg_wr(5'h04, 0, {$urandom, c[31:0]});
            cfg_wr(5'h08, 0, {$urandom, b[63:32]}); cfg_wr(5'h0C, 0, {$urandom, b[31:0]});
        end else begin
            cfg_wr(5'h04, 0, {$urandom, c[31:0]}); cfg_wr(5'h00, 0, {$urandom, c[63:32]});
            cfg_wr(5'h0C, 0, {$urandom, b[31:0]}); cfg_wr(5'h08, 1, b);
        end
    endtask

    task automatic xlate(input logic [31:0] va, input logic [63:0] ent, input int dly, input string tag);
        bit          f;
        logic [63:0] ea, hold;
        logic [40:0] pa;
        logic [31:0] mk;
        logic [1:0]  pm;
        model(sh_ctrl, sh_base, va, ent, f, ea, pa, mk, pm);
        @(negedge clk);
        chk({tag, " R12 ready before"}, 64'(req_ready), 64'd1);
        req_valid = 1; req_vaddr = va;
        @(negedge clk);
        req_valid = 0; req_vaddr = $urandom;
        chk({tag, " fetch issued"}, 64'(mem_req), 64'(f));
        if (f) begin
            chk({tag, " R5/R6 table address"}, mem_addr, ea);
            chk({tag, " R12 busy"}, 64'(req_ready), 64'd0);
            hold = mem_addr;
            for (int i = 0; i < dly; i++) begin
                @(negedge clk);
                chk({tag, " R12 request held"}, {mem_req, mem_addr[62:0]}, {1'b1, hold[62:0]});
            end
            mem_ack = 1; mem_rdata = lanes_of(ent);
            @(negedge clk);
            mem_ack = 0; mem_rdata = {$urandom, $urandom};
        end
        chk({tag, " R12 response pulse"}, 64'(rsp_valid), 64'd1);
        chk({tag, " R10 permission"}, 64'(rsp_perm), 64'(pm));
        chk({tag, " R11 physical address"}, 64'(rsp_paddr), 64'(pa));
        chk({tag, " R11 mask"}, 64'(rsp_mask), 64'(mk));
        @(negedge clk);
        chk({tag, " R12 pulse ends"}, {62'd0, rsp_valid, req_ready}, 64'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] c, e;
        bit          f;
        logic [63:0] ea;
        logic [40:0] pa;
        logic [31:0] mk;
        logic [1:0]  pm;
        void'($urandom(32'd4242));
        rst_n = 0; cfg_valid = 0; cfg_write = 0; cfg_wide = 0; cfg_addr = '0; cfg_wdata = '0;
        req_valid = 0; req_vaddr = '0; mem_ack = 0; mem_rdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ready", 64'(req_ready), 64'd1);
        chk("R1 mem_req", 64'(mem_req), 64'd0);
        chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
        cfg_chk(5'h00, 1, "R1 control zero");
        cfg_chk(5'h08, 1, "R1 base zero");

        // R2 halves and whole
        cfg_wr(5'h00, 1, 64'h1122_3344_5566_7788);
        cfg_chk(5'h00, 1, "R2 wide read");
        cfg_chk(5'h00, 0, "R2 upper half");
        cfg_chk(5'h04, 0, "R2 lower half");
        cfg_wr(5'h08, 1, 64'hA5A5_0000_0000_5A5A);
        cfg_wr(5'h08, 0, 64'hFFFF_FFFF_DEAD_BEEF);
        cfg_chk(5'h08, 1, "R2 narrow upper write keeps lower");
        cfg_wr(5'h0C, 0, 64'h0123_4567_CAFE_F00D);
        cfg_chk(5'h08, 1, "R2 narrow lower write keeps upper");

        // R3 flush window ignored
        cfg_wr(5'h10, 1, '1);
        cfg_wr(5'h14, 0, '1);
        cfg_chk(5'h10, 1, "R3 flush read zero");
        cfg_chk(5'h14, 0, "R3 flush lower read zero");
        cfg_chk(5'h00, 1, "R3 control untouched");
        cfg_chk(5'h08, 1, "R3 base untouched");

        // R4 passthrough
        set_cfg(64'hFFFF_0000_FFFF_FFFE, 64'h0000_0000_1000_0000);
        xlate(32'hDEAD_BEEF, '1, 0, "R4 passthrough");

        // R5 every size in 8K walk
        for (int s = 0; s < 8; s++) begin
            set_cfg(64'h1 | (64'(s) << 16), 64'h0000_0040_0000_0000);
            xlate(32'hFFFF_FFFF, 64'h8000_00AB_CDEF_0002, s % 3, "R5 8K walk");
            xlate($urandom, 64'h8000_0012_3456_0000, 1, "R5 8K walk random");
        end
        // R6 and R7 in 64K walk
        for (int s = 0; s < 8; s++) begin
            set_cfg(64'h5 | (64'(s) << 16), 64'h0000_0000_8000_0000);
            xlate(32'hFFFF_FFFF, 64'hA000_01FF_FFFF_0002, 2, s > 5 ? "R7 unsupported" : "R6 64K walk");
        end

        // R8 byte order, R9 invalid, R10 read-only, R11 big page
        set_cfg(64'h1, 64'h0000_0000_0010_0000);
        xlate(32'h0000_2345, 64'h8000_0102_0304_A002, 0, "R8 lane order");
        xlate(32'h0000_2345, 64'h0000_01FF_FFFF_E002, 1, "R9 invalid entry");
        xlate(32'h0000_2345, 64'h8000_0155_5555_4000, 0, "R10 read-only");
        xlate(32'h0012_ABCD, 64'hA000_00F0_0F0F_0002, 3, "R11 64K page");

        // R13 register write on the acceptance edge
        set_cfg(64'h0000_0000_0002_0001, 64'h0000_0000_2000_0000);
        e = 64'h8000_0077_7777_6002;
        model(sh_ctrl, sh_base, 32'h0123_4567, e, f, ea, pa, mk, pm);
        @(negedge clk);
        cfg_valid = 1; cfg_write = 1; cfg_wide = 0; cfg_addr = 5'h04; cfg_wdata = '0;
        req_valid = 1; req_vaddr = 32'h0123_4567;
        @(negedge clk);
        cfg_valid = 0; cfg_write = 0; req_valid = 0;
        sh_apply(5'h04, 0, 64'd0);
        chk("R13 old config fetches", 64'(mem_req), 64'd1);
        chk("R13 old table address", mem_addr, ea);
        mem_ack = 1; mem_rdata = lanes_of(e);
        @(negedge clk);
        mem_ack = 0;
        chk("R13 old config result", 64'(rsp_paddr), 64'(pa));
        xlate(32'h0123_4567, e, 0, "R13 new config passthrough");

        // random mix
        for (int n = 0; n < 150; n++) begin
            if (n % 8 == 0) begin
                c = {$urandom, $urandom};
                c[0] = ($urandom_range(0, 3) != 0);
                set_cfg(c, {$urandom, $urandom});
                cfg_chk(5'h00, 1, "R2 random control readback");
            end
            e = {$urandom, $urandom};
            e[63] = ($urandom_range(0, 3) != 0);
            xlate($urandom, e, $urandom_range(0, 3), "random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule